// File: doc/BRIEF.md
# Self-Oscillating Half-Bridge Gate Controller

This block is a cycle-level digital model of a half-bridge controller that runs on its own oscillator. A counter stands in for the timing capacitor. It climbs from zero, and once it is between one third and two thirds of full scale it bounces between those two levels. The two crossing points mark the switching instants of two complementary gate enables, one for the low-side switch and one for the high-side switch. After every crossing both enables stay low for a fixed number of clock cycles before the next one turns on.

A digitised supply code passes through a lockout comparator with hysteresis. Nothing switches until the supply is good. The ramp always starts from zero, so the first gate pulse after any start is on the low side, which lets the high-side bootstrap charge first. A bootstrap-enable output follows the low-side enable.

An external shutdown request pulls the ramp to zero. This stops switching without latching. When the request goes away, the ramp climbs again and switching restarts with a low-side pulse.

Top module: `hb_osc_ctrl`

## Requirements
- R1: While the supply is not good, including straight after reset, `lo_en`, `ho_en` and `boot_en` are 0 and `mode` is 0 (lockout).
- R2: From lockout, the supply becomes good when `sup_code` >= 11. Once good, it stays good until `sup_code` < 9, so codes 9 and 10 keep the current state.
- R3: After the supply becomes good, the first enable to rise is `lo_en`. It rises on the sample FS/3 + DT_CYC + 2 cycles after the code first reaches 11, counted from the ramp at zero.
- R4: Between `lo_en` falling and `ho_en` rising, and between `ho_en` falling and `lo_en` rising, both enables are low for exactly DT_CYC cycles.
- R5: With one ramp step per clock, every `lo_en` pulse and every `ho_en` pulse is high for FS/3 - DT_CYC cycles, so the two pulses are equal.
- R6: `lo_en` and `ho_en` are never high in the same cycle.
- R7: `boot_en` is high only in cycles where `lo_en` is high, and in every such cycle.
- R8: Once `sup_code` < 9 is sampled while running, both enables are low by the second clock edge. The next turn-on repeats the R3 sequence.
- R9: While `sd_req` is high, the ramp is held at zero. Both enables are low by the second clock edge after `sd_req` is first sampled, and `mode` reads 1 (hold).
- R10: Shutdown does not latch. After `sd_req` drops, `lo_en` is the first enable to rise, FS/3 + DT_CYC + 1 cycles later.
- R11: While switching with a good supply and the ramp above FS/6, `mode` reads 2 (run).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_code | input | SUP_W | Digitised supply level |
| sd_req | input | 1 | Shutdown request; pulls the ramp to zero |
| lo_en | output | 1 | Low-side gate enable |
| ho_en | output | 1 | High-side gate enable |
| boot_en | output | 1 | Bootstrap charge enable |
| mode | output | 2 | 0 lockout, 1 hold (ramp below FS/6), 2 run |

## Verification
Supply codes of 10, then 11, then 10, then 8, then 10, then 11 separate the turn-on level from the turn-off level and show that the hysteresis band holds either state. A steady supply lets the bench measure pulse widths and gaps exactly, which shows whether the ramp turns around at the right levels and whether the deadtime counter is sized correctly. Shutdown requested in the middle of a high-side pulse, and lockout requested in the middle of a low-side pulse, check that both stop paths override every phase. The exact restart latencies show that the ramp really went back to zero and that the first pulse is on the low side.

// File: rtl/hb_osc_pkg.sv
package hb_osc_pkg;

  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_DT_LO = 3'd1,
    PH_LO    = 3'd2,
    PH_DT_HO = 3'd3,
    PH_HO    = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    MODE_LOCKOUT = 2'd0,
    MODE_HOLD    = 2'd1,
    MODE_RUN     = 2'd2
  } mode_t;

endpackage

// File: rtl/hb_supply_mon.sv
module hb_supply_mon #(
  parameter int SUP_W   = 5,
  parameter int ON_LVL  = 11,
  parameter int OFF_LVL = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUP_W-1:0] sup_code,
  output logic             sup_ok
);

  localparam logic [SUP_W-1:0] ON_V  = SUP_W'(ON_LVL);
  localparam logic [SUP_W-1:0] OFF_V = SUP_W'(OFF_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_ok <= 1'b0;
    end else if (!sup_ok && (sup_code >= ON_V)) begin
      sup_ok <= 1'b1;
    end else if (sup_ok && (sup_code < OFF_V)) begin
      sup_ok <= 1'b0;
    end
  end

endmodule

// File: rtl/hb_ramp_gen.sv
module hb_ramp_gen #(
  parameter int FS       = 96,
  parameter int STEP_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_ok,
  input  logic pull_low,
  output logic at_low,
  output logic at_high,
  output logic below_sd
);

  localparam int RAMP_W = $clog2(FS + 1);
  localparam int DIV_W  = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [RAMP_W-1:0] LOW_V  = RAMP_W'(FS / 3);
  localparam logic [RAMP_W-1:0] HIGH_V = RAMP_W'((2 * FS) / 3);
  localparam logic [RAMP_W-1:0] SD_V   = RAMP_W'(FS / 6);

  logic              tick;
  logic              rising;
  logic [RAMP_W-1:0] ramp;

  generate
    if (STEP_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || (pre == DIV_W'(STEP_DIV - 1))) pre <= '0;
        else                                      pre <= pre + 1'b1;
      end
      assign tick = (pre == DIV_W'(STEP_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !sup_ok || pull_low) begin
      ramp   <= '0;
      rising <= 1'b1;
    end else if (tick) begin
      if (rising) begin
        if (ramp >= HIGH_V) begin
          rising <= 1'b0;
          ramp   <= ramp - 1'b1;
        end else begin
          ramp <= ramp + 1'b1;
        end
      end else begin
        if (ramp <= LOW_V) begin
          rising <= 1'b1;
          ramp   <= ramp + 1'b1;
        end else begin
          ramp <= ramp - 1'b1;
        end
      end
    end
  end

  assign at_low   = tick && (ramp == LOW_V);
  assign at_high  = tick && (ramp == HIGH_V);
  assign below_sd = (ramp < SD_V);

endmodule

// File: rtl/hb_phase_drv.sv
module hb_phase_drv
  import hb_osc_pkg::*;
#(
  parameter int DT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic at_low,
  input  logic at_high,
  output logic lo_en,
  output logic ho_en,
  output logic boot_en
);

  localparam int DT_W = (DT_CYC > 1) ? $clog2(DT_CYC) : 1;
  localparam logic [DT_W-1:0] DT_LAST = DT_W'(DT_CYC - 1);

  phase_t          ph, ph_n;
  logic [DT_W-1:0] dt, dt_n;

  always_comb begin
    ph_n = ph;
    dt_n = dt;
    if (stop) begin
      ph_n = PH_OFF;
      dt_n = '0;
    end else if (at_low) begin
      ph_n = PH_DT_LO;
      dt_n = '0;
    end else if (at_high) begin
      ph_n = PH_DT_HO;
      dt_n = '0;
    end else begin
      case (ph)
        PH_DT_LO: begin
          if (dt == DT_LAST) begin
            ph_n = PH_LO;
            dt_n = '0;
          end else begin
            dt_n = dt + 1'b1;
          end
        end
        PH_DT_HO: begin
          if (dt == DT_LAST) begin
            ph_n = PH_HO;
            dt_n = '0;
          end else begin
            dt_n = dt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_OFF;
      dt      <= '0;
      lo_en   <= 1'b0;
      ho_en   <= 1'b0;
      boot_en <= 1'b0;
    end else begin
      ph      <= ph_n;
      dt      <= dt_n;
      lo_en   <= (ph_n == PH_LO);
      ho_en   <= (ph_n == PH_HO);
      boot_en <= (ph_n == PH_LO);
    end
  end

endmodule

// File: rtl/hb_osc_ctrl.sv
module hb_osc_ctrl
  import hb_osc_pkg::*;
#(
  parameter int SUP_W    = 5,
  parameter int ON_LVL   = 11,
  parameter int OFF_LVL  = 9,
  parameter int FS       = 96,
  parameter int STEP_DIV = 1,
  parameter int DT_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUP_W-1:0] sup_code,
  input  logic             sd_req,
  output logic             lo_en,
  output logic             ho_en,
  output logic             boot_en,
  output logic [1:0]       mode
);

  logic  sup_ok;
  logic  at_low, at_high, below_sd;
  mode_t mode_q;

  hb_supply_mon #(
    .SUP_W  (SUP_W),
    .ON_LVL (ON_LVL),
    .OFF_LVL(OFF_LVL)
  ) u_sup (
    .clk     (clk),
    .rst     (rst),
    .sup_code(sup_code),
    .sup_ok  (sup_ok)
  );

  hb_ramp_gen #(
    .FS      (FS),
    .STEP_DIV(STEP_DIV)
  ) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .sup_ok  (sup_ok),
    .pull_low(sd_req),
    .at_low  (at_low),
    .at_high (at_high),
    .below_sd(below_sd)
  );

  hb_phase_drv #(
    .DT_CYC(DT_CYC)
  ) u_drv (
    .clk    (clk),
    .rst    (rst),
    .stop   (!sup_ok || below_sd),
    .at_low (at_low),
    .at_high(at_high),
    .lo_en  (lo_en),
    .ho_en  (ho_en),
    .boot_en(boot_en)
  );

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= MODE_LOCKOUT;
    else if (!sup_ok)  mode_q <= MODE_LOCKOUT;
    else if (below_sd) mode_q <= MODE_HOLD;
    else               mode_q <= MODE_RUN;
  end

  assign mode = mode_q;

endmodule

// File: rtl/hb_osc_chk.sv
module hb_osc_chk
  import hb_osc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       lo_en,
  input logic       ho_en,
  input logic       boot_en,
  input logic       sup_ok,
  input logic [1:0] mode
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(lo_en && ho_en)); // R6

  AST_BOOT_WITH_LO: assert property (@(posedge clk) disable iff (rst)
    boot_en |-> lo_en); // R7

  AST_GAP_BEFORE_HO: assert property (@(posedge clk) disable iff (rst)
    $rose(ho_en) |-> !$past(lo_en)); // R4

  AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_en) |-> !$past(ho_en)); // R4

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sup_ok |=> (!lo_en && !ho_en)); // R1

  AST_LOCKOUT_MODE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOCKOUT) |-> (!lo_en && !ho_en && !boot_en)); // R8

endmodule

bind hb_osc_ctrl hb_osc_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .lo_en  (lo_en),
  .ho_en  (ho_en),
  .boot_en(boot_en),
  .sup_ok (sup_ok),
  .mode   (mode)
);

// File: tb/sim_hb_osc_ctrl.sv
module sim_hb_osc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SUP_W  = 5;
  localparam int FS     = 96;
  localparam int DT     = 4;
  localparam int WIDTH  = FS / 3 - DT;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SUP_W-1:0] sup_code = '0;
  logic             sd_req = 1'b0;
  logic             lo_en, ho_en, boot_en;
  logic [1:0]       mode;

  int n_chk  = 0;
  int n_fail = 0;
  int n_overlap = 0;
  int n_bootbad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hb_osc_ctrl #(
    .SUP_W(SUP_W), .ON_LVL(11), .OFF_LVL(9),
    .FS(FS), .STEP_DIV(1), .DT_CYC(DT)
  ) u0 (
    .clk(clk), .rst(rst), .sup_code(sup_code), .sd_req(sd_req),
    .lo_en(lo_en), .ho_en(ho_en), .boot_en(boot_en), .mode(mode)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (lo_en && ho_en) n_overlap++;
      if (boot_en != lo_en) n_bootbad++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic count_to_first(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!lo_en && !ho_en && cnt < 1000);
  endtask

  task automatic count_active(input int cycles, output int hits);
    hits = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (lo_en || ho_en || boot_en) hits++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    sup_code = '0;
    sd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!lo_en && !ho_en && !boot_en, "R1 outputs after reset",
          int'({lo_en, ho_en, boot_en}), 0);
    check(mode == 2'd0, "R1 mode after reset", int'(mode), 0);
  endtask

  task automatic t_below_on();
    int hits;
    sup_code = 5'd10;
    count_active(150, hits);
    check(hits == 0, "R2 code 10 from lockout stays off", hits, 0);
    check(mode == 2'd0, "R1 mode in lockout", int'(mode), 0);
  endtask

  task automatic t_startup_widths();
    int cnt, n;
    sup_code = 5'd11;
    count_to_first(cnt);
    check(lo_en && !ho_en, "R3 first pulse is low side", int'({lo_en, ho_en}), 2);
    check(cnt == FS / 3 + DT + 2, "R3 turn-on latency", cnt, FS / 3 + DT + 2);
    check(mode == 2'd2, "R11 mode while switching", int'(mode), 2);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      while (lo_en) begin n++; @(negedge clk); end
      check(n == WIDTH, "R5 low-side pulse width", n, WIDTH);
      n = 0;
      while (!lo_en && !ho_en) begin n++; @(negedge clk); end
      check(n == DT && ho_en, "R4 gap before high side", n, DT);
      n = 0;
      while (ho_en) begin n++; @(negedge clk); end
      check(n == WIDTH, "R5 high-side pulse width", n, WIDTH);
      n = 0;
      while (!lo_en && !ho_en) begin n++; @(negedge clk); end
      check(n == DT && lo_en, "R4 gap before low side", n, DT);
    end
  endtask

  task automatic t_hysteresis();
    int rises, hits, cnt;
    logic prev;
    sup_code = 5'd10;
    rises = 0;
    prev = lo_en;
    repeat (300) begin
      @(negedge clk);
      if (lo_en && !prev) rises++;
      prev = lo_en;
    end
    check(rises >= 3, "R2 code 10 keeps running", rises, 3);
    while (!lo_en) @(negedge clk);
    sup_code = 5'd8;
    repeat (2) @(negedge clk);
    check(!lo_en && !ho_en && !boot_en, "R8 off within two edges",
          int'({lo_en, ho_en, boot_en}), 0);
    check(mode == 2'd0, "R8 mode lockout", int'(mode), 0);
    sup_code = 5'd10;
    count_active(150, hits);
    check(hits == 0, "R2 code 10 after lockout stays off", hits, 0);
    sup_code = 5'd11;
    count_to_first(cnt);
    check(lo_en && !ho_en, "R8 restart low side first", int'({lo_en, ho_en}), 2);
    check(cnt == FS / 3 + DT + 2, "R3 restart latency", cnt, FS / 3 + DT + 2);
  endtask

  task automatic t_shutdown();
    int hits, cnt;
    while (!ho_en) @(negedge clk);
    sd_req = 1'b1;
    repeat (2) @(negedge clk);
    check(!lo_en && !ho_en && !boot_en, "R9 shutdown stops outputs",
          int'({lo_en, ho_en, boot_en}), 0);
    check(mode == 2'd1, "R9 mode hold", int'(mode), 1);
    count_active(100, hits);
    check(hits == 0, "R9 quiet during shutdown", hits, 0);
    sd_req = 1'b0;
    count_to_first(cnt);
    check(lo_en && !ho_en, "R10 resume low side first", int'({lo_en, ho_en}), 2);
    check(cnt == FS / 3 + DT + 1, "R10 resume latency", cnt, FS / 3 + DT + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report_end();
  end

  initial begin
    t_reset();
    t_below_on();
    t_startup_widths();
    t_hysteresis();
    t_shutdown();
    repeat (200) @(negedge clk);
    check(n_overlap == 0, "R6 enables never overlap", n_overlap, 0);
    check(n_bootbad == 0, "R7 bootstrap follows low side", n_bootbad, 0);
    report_end();
  end

endmodule